// File: doc/BRIEF.md
# BFloat16 Pairwise Dot-Product Accumulator

This unit takes a vector of BFloat16 pairs, multiplies every pair by one shared BFloat16 pair, and adds each two-term dot product into a single-precision accumulator lane. The shared pair is picked out of a 128-bit second operand by a 2-bit index and broadcast to all lanes. A width input chooses between a 128-bit vector (four 32-bit lanes) and a 64-bit vector (two lanes).

The arithmetic is deliberately unfused. Each product is rounded to FP32, the two products are summed and rounded, and that sum is then added to the accumulator lane and rounded once more. Every rounding step truncates and sets bit 0 when the result is inexact. Denormals are flushed to signed zero, NaN results are always the default NaN, and no exception status leaves the block. A single FP32 multiplier and a single FP32 adder are shared: the unit visits the lanes in turn, three cycles per lane, keeps its input ready low while busy and signals completion with a one-cycle valid pulse.

Top module: `bfd_dot_acc`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_result` is all zeros.
- R2: `in_idx` = i selects 16-bit elements 2i (first factor, bits [32i+15:32i]) and 2i+1 (second factor, bits [32i+31:32i+16]) of `in_opb`; the other six elements of `in_opb` have no effect on the result.
- R3: Lane e multiplies element 2e of `in_opa` (bits [32e+15:32e]) by the first selected factor and element 2e+1 (bits [32e+31:32e+16]) by the second, and reads and writes 32-bit word e of `in_acc` and `out_result`.
- R4: `in_wide` = 1 gives four lanes; `in_wide` = 0 gives two lanes and `out_result[127:64]` is zero whatever the upper halves of the operands hold.
- R5: Each BF16 (widened by appending 16 zero bits) product is rounded to FP32, their sum is rounded, and the rounded sum is added to the accumulator word and rounded again.
- R6: Every rounding truncates the exact value toward zero and sets bit 0 of the result if any discarded bit was nonzero; an exact result is unchanged.
- R7: A result whose exponent exceeds the FP32 range becomes infinity with the result's sign (0x7F800000 or 0xFF800000).
- R8: An operand or intermediate with exponent field 0 is treated as a zero of its sign, and any result below the smallest normal becomes a zero of its sign; a result never has exponent 0 with a nonzero fraction.
- R9: Any NaN operand, infinity times zero, and the sum of opposite-signed infinities produce 0x7FC00000.
- R10: An infinite operand otherwise passes through with the correct sign; a sum of two zeros is -0 only if both are -0, otherwise +0.
- R11: A request is taken on a clock edge with `in_valid` and `in_ready` high; `in_ready` then stays low, and `out_valid` is high for exactly one cycle, beginning 3 x (lane count) edges after the accepting edge, with `out_result` held until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle and able to take a request |
| in_wide | input | 1 | 1: 128-bit vector, 0: 64-bit vector |
| in_idx | input | 2 | Selects the BF16 pair in `in_opb` |
| in_opa | input | 128 | BF16 pairs, one pair per lane |
| in_opb | input | 128 | Four BF16 pairs, one chosen by `in_idx` |
| in_acc | input | 128 | FP32 accumulator words, one per lane |
| out_valid | output | 1 | One-cycle result strobe |
| out_result | output | 128 | FP32 result words, one per lane |

## Verification
The hardest cases to reach from the ports are the ones that only the unfused ordering exposes: an intermediate sum that is inexact and then cancelled by the accumulator, and an intermediate sum that falls below the normal range and must be flushed before accumulation. The stimulus reaches them by pairing a BF16 factor near 1.0 with one near 2^-30, so that the rounded sum carries a forced bit 0 that survives subtraction of 1.0, and by pairing products of 1.5 x 2^-126 and -2^-126 whose difference is denormal. Every table row rotates through all four index values and both widths, with the unselected pairs of the second operand set to infinity so a wrong selection shows up at once.

// File: rtl/bfd_pkg.sv
package bfd_pkg;

    localparam int FP_W = 32;
    localparam int BF_W = 16;
    localparam logic [FP_W-1:0] QNAN_DEFAULT = 32'h7FC00000;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctl_e;

    typedef enum logic [1:0] {
        PH_PROD0 = 2'd0,
        PH_PROD1 = 2'd1,
        PH_ACCUM = 2'd2
    } ph_e;

    function automatic logic [FP_W-1:0] widen_bf16(input logic [BF_W-1:0] v);
        return {v, {(FP_W-BF_W){1'b0}}};
    endfunction

endpackage

// File: rtl/bfd_fmul.sv
// FP32 multiply: round-to-odd, flush-to-zero, default NaN.
module bfd_fmul
    import bfd_pkg::*;
(
    input  logic [FP_W-1:0] mul_a,
    input  logic [FP_W-1:0] mul_b,
    output logic [FP_W-1:0] mul_z
);
    logic              sgn;
    logic [7:0]        ea, eb;
    logic [22:0]       fa, fb;
    logic              a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic [47:0]       prod;
    logic signed [10:0] e_w;
    logic [22:0]       frac;
    logic              sticky;

    always_comb begin
        sgn    = mul_a[31] ^ mul_b[31];
        ea     = mul_a[30:23];
        eb     = mul_b[30:23];
        fa     = mul_a[22:0];
        fb     = mul_b[22:0];
        a_nan  = (ea == 8'hFF) && (fa != 23'd0);
        b_nan  = (eb == 8'hFF) && (fb != 23'd0);
        a_inf  = (ea == 8'hFF) && (fa == 23'd0);
        b_inf  = (eb == 8'hFF) && (fb == 23'd0);
        a_zero = (ea == 8'd0);
        b_zero = (eb == 8'd0);
        prod   = 48'({1'b1, fa}) * 48'({1'b1, fb});
        e_w    = $signed({3'b000, ea}) + $signed({3'b000, eb}) - 11'sd127;
        if (prod[47]) begin
            frac   = prod[46:24];
            sticky = |prod[23:0];
            e_w    = e_w + 11'sd1;
        end else begin
            frac   = prod[45:23];
            sticky = |prod[22:0];
        end

        if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero)) begin
            mul_z = QNAN_DEFAULT;
        end else if (a_inf || b_inf) begin
            mul_z = {sgn, 8'hFF, 23'd0};
        end else if (a_zero || b_zero) begin
            mul_z = {sgn, 31'd0};
        end else if (e_w >= 11'sd255) begin
            mul_z = {sgn, 8'hFF, 23'd0};
        end else if (e_w <= 11'sd0) begin
            mul_z = {sgn, 31'd0};
        end else begin
            mul_z = {sgn, e_w[7:0], frac[22:1], frac[0] | sticky};
        end
    end

endmodule

// File: rtl/bfd_fadd.sv
// FP32 add: round-to-odd, flush-to-zero, default NaN.
module bfd_fadd
    import bfd_pkg::*;
(
    input  logic [FP_W-1:0] add_a,
    input  logic [FP_W-1:0] add_b,
    output logic [FP_W-1:0] add_z
);
    localparam int EXT_W = 27;

    logic [7:0]        ea, eb, e_big, e_sml, dexp;
    logic [22:0]       fa, fb, f_big, f_sml;
    logic              sa, sb, s_big, s_sml;
    logic              a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, swap;
    logic [EXT_W-1:0]  m_big, m_sml, m_sh, lost_mask, norm;
    logic [EXT_W:0]    sum;
    logic [4:0]        lz;
    logic signed [9:0] e_w;

    always_comb begin
        {sa, ea, fa} = add_a;
        {sb, eb, fb} = add_b;
        a_nan  = (ea == 8'hFF) && (fa != 23'd0);
        b_nan  = (eb == 8'hFF) && (fb != 23'd0);
        a_inf  = (ea == 8'hFF) && (fa == 23'd0);
        b_inf  = (eb == 8'hFF) && (fb == 23'd0);
        a_zero = (ea == 8'd0);
        b_zero = (eb == 8'd0);

        swap  = {eb, fb} > {ea, fa};
        s_big = swap ? sb : sa;
        e_big = swap ? eb : ea;
        f_big = swap ? fb : fa;
        s_sml = swap ? sa : sb;
        e_sml = swap ? ea : eb;
        f_sml = swap ? fa : fb;
        dexp  = e_big - e_sml;
        m_big = {1'b1, f_big, 3'b000};
        m_sml = {1'b1, f_sml, 3'b000};

        lost_mask = '0;
        if (dexp >= 8'(EXT_W)) begin
            m_sh = {{(EXT_W-1){1'b0}}, 1'b1};
        end else begin
            lost_mask = (27'd1 << dexp) - 27'd1;
            m_sh      = m_sml >> dexp;
            m_sh[0]   = m_sh[0] | (|(m_sml & lost_mask));
        end

        if (s_big != s_sml) sum = {1'b0, m_big} - {1'b0, m_sh};
        else                sum = {1'b0, m_big} + {1'b0, m_sh};

        lz = 5'd0;
        for (int i = 0; i < EXT_W; i++) begin
            if (sum[i]) lz = 5'(EXT_W - 1 - i);
        end

        e_w = $signed({2'b00, e_big});
        if (sum[EXT_W]) begin
            norm = {sum[EXT_W:2], sum[1] | sum[0]};
            e_w  = e_w + 10'sd1;
        end else begin
            norm = sum[EXT_W-1:0] << lz;
            e_w  = e_w - $signed({5'd0, lz});
        end

        if (a_nan || b_nan || (a_inf && b_inf && (sa != sb))) begin
            add_z = QNAN_DEFAULT;
        end else if (a_inf) begin
            add_z = add_a;
        end else if (b_inf) begin
            add_z = add_b;
        end else if (a_zero && b_zero) begin
            add_z = {sa & sb, 31'd0};
        end else if (a_zero) begin
            add_z = add_b;
        end else if (b_zero) begin
            add_z = add_a;
        end else if (sum == '0) begin
            add_z = '0;
        end else if (e_w >= 10'sd255) begin
            add_z = {s_big, 8'hFF, 23'd0};
        end else if (e_w <= 10'sd0) begin
            add_z = {s_big, 31'd0};
        end else begin
            add_z = {s_big, e_w[7:0], norm[25:4], norm[3] | (|norm[2:0])};
        end
    end

endmodule

// File: rtl/bfd_dot_acc.sv
module bfd_dot_acc
    import bfd_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int NUM_PAIRS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic                        in_wide,
    input  logic [$clog2(NUM_PAIRS)-1:0] in_idx,
    input  logic [NUM_LANES*32-1:0]     in_opa,
    input  logic [NUM_PAIRS*32-1:0]     in_opb,
    input  logic [NUM_LANES*32-1:0]     in_acc,
    output logic                        out_valid,
    output logic [NUM_LANES*32-1:0]     out_result
);
    localparam int VEC_W  = NUM_LANES * FP_W;
    localparam int LANE_W = $clog2(NUM_LANES);
    localparam logic [LANE_W-1:0] LAST_WIDE   = LANE_W'(NUM_LANES - 1);
    localparam logic [LANE_W-1:0] LAST_NARROW = LANE_W'(NUM_LANES / 2 - 1);

    typedef struct packed {
        ctl_e              state;
        ph_e               phase;
        logic [LANE_W-1:0] lane;
        logic              wide;
        logic [VEC_W-1:0]  opa;
        logic [FP_W-1:0]   bpair;
        logic [VEC_W-1:0]  acc;
        logic [FP_W-1:0]   part;
        logic [VEC_W-1:0]  res;
    } regs_t;

    regs_t q, d;

    logic [FP_W-1:0] lane_word, acc_word;
    logic [FP_W-1:0] mul_x, mul_y, mul_z, add_x, add_y, add_z;
    logic            second;
    logic            wide_q;

    assign lane_word = q.opa[q.lane*FP_W +: FP_W];
    assign acc_word  = q.acc[q.lane*FP_W +: FP_W];
    assign second    = (q.phase == PH_PROD1);
    assign mul_x     = widen_bf16(second ? lane_word[31:16] : lane_word[15:0]);
    assign mul_y     = widen_bf16(second ? q.bpair[31:16] : q.bpair[15:0]);
    assign add_x     = q.part;
    assign add_y     = second ? mul_z : acc_word;

    bfd_fmul u_mul (.mul_a(mul_x), .mul_b(mul_y), .mul_z(mul_z));
    bfd_fadd u_add (.add_a(add_x), .add_b(add_y), .add_z(add_z));

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (in_valid) begin
                    d.state = ST_RUN;
                    d.phase = PH_PROD0;
                    d.lane  = '0;
                    d.wide  = in_wide;
                    d.opa   = in_opa;
                    d.bpair = in_opb[in_idx*FP_W +: FP_W];
                    d.acc   = in_acc;
                    d.res   = '0;
                end
            end
            ST_RUN: begin
                case (q.phase)
                    PH_PROD0: begin
                        d.part  = mul_z;
                        d.phase = PH_PROD1;
                    end
                    PH_PROD1: begin
                        d.part  = add_z;
                        d.phase = PH_ACCUM;
                    end
                    default: begin
                        d.res[q.lane*FP_W +: FP_W] = add_z;
                        d.phase = PH_PROD0;
                        if (q.lane == (q.wide ? LAST_WIDE : LAST_NARROW)) begin
                            d.state = ST_DONE;
                        end else begin
                            d.lane = q.lane + LANE_W'(1);
                        end
                    end
                endcase
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign in_ready   = (q.state == ST_IDLE);
    assign out_valid  = (q.state == ST_DONE);
    assign out_result = q.res;
    assign wide_q     = q.wide;

endmodule

// File: rtl/bfd_dot_acc_chk.sv
module bfd_dot_acc_chk #(
    parameter int NUM_LANES = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic [NUM_LANES*32-1:0] out_result,
    input logic                    wide_q
);
    localparam int HALF_W = NUM_LANES * 16;

    assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_busy_on_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_idle_holds_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> $stable(out_result));

    assert_narrow_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !wide_q) |-> (out_result[NUM_LANES*32-1:HALF_W] == '0));

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [7:0]  ex;
        logic [22:0] fr;
        assign ex = out_result[g*32+23 +: 8];
        assign fr = out_result[g*32 +: 23];

        assert_default_nan_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ex == 8'hFF && fr != 23'd0) |-> (out_result[g*32 +: 32] == 32'h7FC00000));

        assert_no_denormal_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ex == 8'd0) |-> (fr == 23'd0));
    end

endmodule

bind bfd_dot_acc bfd_dot_acc_chk #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_result (out_result),
    .wide_q     (wide_q)
);

// File: tb/bfd_dot_acc_bench.sv
`timescale 1ns/1ps
module bfd_dot_acc_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic         in_wide = 1'b0;
    logic [1:0]   in_idx = 2'd0;
    logic [127:0] in_opa = '0;
    logic [127:0] in_opb = '0;
    logic [127:0] in_acc = '0;
    logic         out_valid;
    logic [127:0] out_result;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    bfd_dot_acc u_bfd_dot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_wide(in_wide), .in_idx(in_idx), .in_opa(in_opa), .in_opb(in_opb),
        .in_acc(in_acc), .out_valid(out_valid), .out_result(out_result)
    );

    // {req, a0, a1, b0, b1, acc, expected}
    localparam int NV = 21;
    localparam logic [135:0] TV [NV] = '{
        {8'd2,  16'h3F80, 16'h4000, 16'h4040, 16'h3F00, 32'h3F800000, 32'h40A00000}, // R2 exact
        {8'd2,  16'h3FC0, 16'hBF80, 16'h4000, 16'h4000, 32'h3E800000, 32'h3FA00000}, // R2 mixed sign
        {8'd6,  16'h3F80, 16'h0000, 16'h3F80, 16'h0000, 32'h30800000, 32'h3F800001}, // R6 sticky on add
        {8'd5,  16'h3F80, 16'h3080, 16'h3F80, 16'h3F80, 32'hBF800000, 32'h34000000}, // R5 rounded sum kept
        {8'd7,  16'h7F7F, 16'h7F7F, 16'h3F80, 16'h3F80, 32'h00000000, 32'h7F800000}, // R7 sum overflow
        {8'd7,  16'h7F7F, 16'h7F7F, 16'hBF80, 16'hBF80, 32'h00000000, 32'hFF800000}, // R7 negative
        {8'd7,  16'h7F00, 16'h0000, 16'h4000, 16'h0000, 32'h00000000, 32'h7F800000}, // R7 product overflow
        {8'd8,  16'h0001, 16'h3F80, 16'h4000, 16'h4000, 32'h00000000, 32'h40000000}, // R8 denormal input
        {8'd8,  16'h0080, 16'h0000, 16'h3F00, 16'h0000, 32'h00000000, 32'h00000000}, // R8 product underflow
        {8'd8,  16'h00C0, 16'h8080, 16'h3F80, 16'h3F80, 32'h3F800000, 32'h3F800000}, // R8 sum underflow
        {8'd8,  16'h3F80, 16'h0000, 16'h3F80, 16'h0000, 32'h00000003, 32'h3F800000}, // R8 denormal acc
        {8'd9,  16'hFFA1, 16'h3F80, 16'h3F80, 16'h3F80, 32'h3F800000, 32'h7FC00000}, // R9 NaN input
        {8'd9,  16'h7F80, 16'h3F80, 16'h0000, 16'h3F80, 32'h00000000, 32'h7FC00000}, // R9 inf*0
        {8'd9,  16'h7F80, 16'hFF80, 16'h3F80, 16'h3F80, 32'h3F800000, 32'h7FC00000}, // R9 inf-inf
        {8'd9,  16'h3F80, 16'h3F80, 16'h3F80, 16'h3F80, 32'h7F800001, 32'h7FC00000}, // R9 NaN acc
        {8'd10, 16'hFF80, 16'h3F80, 16'h3F80, 16'h3F80, 32'h3F800000, 32'hFF800000}, // R10 -inf
        {8'd9,  16'h7F80, 16'h0000, 16'h3F80, 16'h3F80, 32'hFF800000, 32'h7FC00000}, // R9 inf vs acc
        {8'd10, 16'h8000, 16'h8000, 16'h3F80, 16'h3F80, 32'h80000000, 32'h80000000}, // R10 -0
        {8'd10, 16'h8000, 16'h0000, 16'h3F80, 16'h3F80, 32'h80000000, 32'h00000000}, // R10 +0
        {8'd6,  16'h3F80, 16'h0000, 16'h3F80, 16'h0000, 32'hB0800000, 32'h3F7FFFFF}, // R6 sticky on sub
        {8'd6,  16'h3F80, 16'h3F80, 16'h3F81, 16'h3F80, 32'h00000000, 32'h40008000}  // R6 exact
    };

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic wide, input logic [1:0] idx, input logic [127:0] a,
                       input logic [127:0] b, input logic [127:0] c,
                       output logic [127:0] res, output int lat, output int busy_bad,
                       output logic pulse_bad);
        @(negedge clk);
        in_wide = wide; in_idx = idx; in_opa = a; in_opb = b; in_acc = c; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 0; busy_bad = 0;
        while (lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (out_valid) break;
            if (in_ready) busy_bad++;
        end
        res = out_result;
        @(negedge clk);
        pulse_bad = out_valid;
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [127:0] a, b, c, res, exp;
        int lat, busy_bad;
        logic pulse_bad;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ready", {127'd0, in_ready}, 128'd1);
        check("R1 valid", {127'd0, out_valid}, 128'd0);
        check("R1 result", out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready after release", {127'd0, in_ready}, 128'd1);

        for (int r = 0; r < NV; r++) begin
            logic [7:0]  req;
            logic [15:0] a0, a1, b0, b1;
            logic [31:0] cw, ew;
            logic        wide;
            logic [1:0]  idx;
            string       tag;
            {req, a0, a1, b0, b1, cw, ew} = TV[r];
            idx  = 2'(r % 4);
            wide = ((r % 8) >= 4);
            for (int e = 0; e < 4; e++) begin
                a[e*32 +: 32] = {a1, a0};
                c[e*32 +: 32] = cw;
            end
            for (int p = 0; p < 4; p++)
                b[p*32 +: 32] = (p == int'(idx)) ? {b1, b0} : {16'h7F80, 16'h7F80};
            run(wide, idx, a, b, c, res, lat, busy_bad, pulse_bad);
            tag = $sformatf("R%0d row %0d idx %0d wide %0d", req, r, idx, wide);
            for (int e = 0; e < 4; e++) begin
                exp[e*32 +: 32] = (wide || e < 2) ? ew : 32'd0;
            end
            check(tag, res, exp);                                       // R2 R4 + row tag
            check($sformatf("R11 latency row %0d", r), 128'(lat), 128'(wide ? 12 : 6));
            check($sformatf("R11 ready low row %0d", r), 128'(busy_bad), 128'd0);
            check($sformatf("R11 one-cycle pulse row %0d", r), {127'd0, pulse_bad}, 128'd0);
        end

        // R3 distinct lanes, wide
        a = {16'h4080, 16'h4080, 16'h4040, 16'h4040, 16'h4000, 16'h4000, 16'h3F80, 16'h3F80};
        b = {32'h7F807F80, 32'h3F803F80, 32'h7F807F80, 32'h7F807F80};
        c = {32'd0, 32'd0, 32'd0, 32'h3F800000};
        run(1'b1, 2'd2, a, b, c, res, lat, busy_bad, pulse_bad);
        check("R3 lanes wide", res, {32'h41000000, 32'h40C00000, 32'h40800000, 32'h40400000});

        // R4 same lanes, narrow: upper words dropped
        run(1'b0, 2'd2, a, b, c, res, lat, busy_bad, pulse_bad);
        check("R4 lanes narrow", res, {64'd0, 32'h40800000, 32'h40400000});
        check("R11 latency narrow", 128'(lat), 128'd6);

        // R11 idle result held
        repeat (5) @(negedge clk);
        check("R11 result held idle", out_result, {64'd0, 32'h40800000, 32'h40400000});
        check("R11 ready idle", {127'd0, in_ready}, 128'd1);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule